// File: doc/BRIEF.md
# Packed Video Min/Max Datapath

This block executes one packed-video integer minimum/maximum operation per accepted input. A 64-bit instruction word arrives together with three 32-bit source values A, B and C and a valid strobe. From the instruction the block decodes, for each of A and B, an operand width (8, 16 or 32 bits), a lane select and a signedness. Operand B can instead come from a 20-bit immediate field. The selected lane of each operand is extended to a common width. The two values are then compared exactly, even when one is signed and the other is unsigned.

The chosen value can be clamped to the range of the destination's signedness. A post stage then combines it with C: the result can be inserted into a byte or halfword lane of C, added to C, compared again against C for a min or max, or passed through unchanged. The final 32-bit value is held in a result register. An output valid flag follows the input strobe by one clock.

Top module: `packed_minmax_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is 0. The reset takes effect without waiting for a clock edge.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `result` loads only on a clock with `in_valid` high. Otherwise `result` keeps its value, whatever the other inputs do.
- R3: Operand A is described by instr[38:37], instr[37:36] and instr[48].
  - The size code is instr[38:37]: 3 means 32-bit, 2 means 16-bit, and 0 or 1 means 8-bit.
  - The lane select is instr[37:36]. An 8-bit operand takes byte lane `sel` of `src_a`. A 16-bit operand takes the upper half when instr[36]=1 and the lower half otherwise. A 32-bit operand takes the whole word.
  - When instr[48]=1 the operand is sign-extended; otherwise it is zero-extended.
- R4: When instr[50]=1, operand B comes from `src_b`. It uses the same size and lane rules with size code instr[30:29] and lane select instr[29:28], and it is signed when instr[49]=1.
- R5: When instr[50]=0, operand B is the 20-bit field instr[35:16]. It is sign-extended to 32 bits when instr[49]=1 and zero-extended otherwise.
- R6: instr[56]=1 selects the larger operand and instr[56]=0 the smaller. When both operands have the same signedness, the comparison and the result use that signedness.
- R7: When the operand signedness differs, the comparison is exact over the full value ranges. The result of a max counts as unsigned and the result of a min counts as signed.
- R8: With instr[55]=1 (saturate) and instr[54]=1 (signed destination), an unsigned-typed result above 0x7FFFFFFF becomes 0x7FFFFFFF. Without saturation the value is unchanged.
- R9: With instr[55]=1 and instr[54]=0, a signed-typed negative result becomes 0.
- R10: The post code in instr[53:51] selects a lane insert, with all other bits of `src_c` unchanged:
  - 0 puts the low 16 result bits into C[31:16].
  - 1 puts them into C[15:0].
  - 2 puts the low result byte into C[7:0].
  - 3 puts it into C[23:16].
- R11: Post code 4 outputs the result plus `src_c`, modulo 2^32. Post code 7 outputs the result unchanged.
- R12: Post codes 5 and 6 output the minimum or the maximum of the result and `src_c`. The comparison is signed when instr[54]=1 and unsigned otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | Operation strobe |
| instr | input | 64 | Instruction word carrying all control fields |
| src_a | input | 32 | Operand A register value |
| src_b | input | 32 | Operand B register value (unused for the immediate form) |
| src_c | input | 32 | Post-operation operand |
| out_valid | output | 1 | High one cycle after an accepted operation |
| result | output | 32 | Registered final value |

## Verification
The hardest situation to reach is a mixed-signedness compare in which the unsigned operand has its top bit set and the signed operand is negative. In that case a plain signed or a plain unsigned compare picks the wrong operand. A further hard case adds saturation toward the opposite destination signedness on top of that compare. Random instruction words seldom land there, so directed vectors place 0x80000000 against -1 and 0x90000000 against a small value. Random words with random data then cover the remaining lane, size and post-code combinations against a bench model.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
  localparam int WORD_W  = 32;
  localparam int INSTR_W = 64;
  localparam int IMM_W   = 20;
  localparam int BYTE_W  = WORD_W / 4;
  localparam int HALF_W  = WORD_W / 2;
  localparam int EXT_W   = WORD_W + 1;

  typedef enum logic [2:0] {
    POST_INS_HI16 = 3'd0,
    POST_INS_LO16 = 3'd1,
    POST_INS_B0   = 3'd2,
    POST_INS_B2   = 3'd3,
    POST_ADD      = 3'd4,
    POST_MIN      = 3'd5,
    POST_MAX      = 3'd6,
    POST_PASS     = 3'd7
  } post_op_e;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2
  } lane_size_e;

  typedef struct packed {
    lane_size_e size;
    logic [1:0] sel;
    logic       sgn;
  } operand_ctl_t;

  typedef struct packed {
    operand_ctl_t      a;
    operand_ctl_t      b;
    logic              b_is_reg;
    logic [WORD_W-1:0] imm_ext;
    logic              want_max;
    logic              sat;
    logic              dst_sgn;
    post_op_e          post;
  } op_ctl_t;

  function automatic lane_size_e size_of(input logic [1:0] code);
    case (code)
      2'd3:    return SZ_32;
      2'd2:    return SZ_16;
      default: return SZ_8;
    endcase
  endfunction

  function automatic logic [1:0] sel_of(input lane_size_e sz, input logic [1:0] raw);
    case (sz)
      SZ_16:   return {1'b0, raw[0]};
      SZ_32:   return 2'd0;
      default: return raw;
    endcase
  endfunction
endpackage

// File: rtl/pmm_decode.sv
module pmm_decode
  import pmm_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output op_ctl_t            ctl
);
  localparam int A_SEL_LO  = 36;
  localparam int A_SZ_LO   = 37;
  localparam int B_SEL_LO  = 28;
  localparam int B_SZ_LO   = 29;
  localparam int IMM_LO    = 16;
  localparam int A_SGN_BIT = 48;
  localparam int B_SGN_BIT = 49;
  localparam int B_REG_BIT = 50;
  localparam int POST_LO   = 51;
  localparam int DSGN_BIT  = 54;
  localparam int SAT_BIT   = 55;
  localparam int MAX_BIT   = 56;

  lane_size_e        a_size, b_size;
  logic [IMM_W-1:0]  imm_raw;
  logic              unused_instr_bits;

  assign unused_instr_bits = ^{instr[INSTR_W-1:MAX_BIT+1], instr[A_SGN_BIT-1:A_SZ_LO+2],
                               instr[IMM_LO-1:0]};

  always_comb begin
    a_size  = size_of(instr[A_SZ_LO +: 2]);
    b_size  = size_of(instr[B_SZ_LO +: 2]);
    imm_raw = instr[IMM_LO +: IMM_W];

    ctl.a.size = a_size;
    ctl.a.sel  = sel_of(a_size, instr[A_SEL_LO +: 2]);
    ctl.a.sgn  = instr[A_SGN_BIT];

    ctl.b.size = b_size;
    ctl.b.sel  = sel_of(b_size, instr[B_SEL_LO +: 2]);
    ctl.b.sgn  = instr[B_SGN_BIT];

    ctl.b_is_reg = instr[B_REG_BIT];
    ctl.imm_ext  = {{(WORD_W-IMM_W){instr[B_SGN_BIT] & imm_raw[IMM_W-1]}}, imm_raw};
    ctl.want_max = instr[MAX_BIT];
    ctl.sat      = instr[SAT_BIT];
    ctl.dst_sgn  = instr[DSGN_BIT];
    ctl.post     = post_op_e'(instr[POST_LO +: 3]);
  end
endmodule

// File: rtl/pmm_lane_extract.sv
module pmm_lane_extract
  import pmm_pkg::*;
(
  input  logic [WORD_W-1:0] raw,
  input  operand_ctl_t      ctl,
  output logic [EXT_W-1:0]  ext
);
  localparam int SH_W = $clog2(WORD_W);

  logic [SH_W-1:0]   shamt;
  logic [WORD_W-1:0] shifted;
  logic              unused_shift_bits;

  assign unused_shift_bits = ^shifted[WORD_W-1:HALF_W];

  always_comb begin
    case (ctl.size)
      SZ_8:    shamt = SH_W'(ctl.sel) * SH_W'(BYTE_W);
      SZ_16:   shamt = SH_W'(ctl.sel) * SH_W'(HALF_W);
      default: shamt = '0;
    endcase
    shifted = raw >> shamt;
  end

  always_comb begin
    case (ctl.size)
      SZ_8:    ext = {{(EXT_W-BYTE_W){ctl.sgn & shifted[BYTE_W-1]}}, shifted[BYTE_W-1:0]};
      SZ_16:   ext = {{(EXT_W-HALF_W){ctl.sgn & shifted[HALF_W-1]}}, shifted[HALF_W-1:0]};
      default: ext = {ctl.sgn & raw[WORD_W-1], raw};
    endcase
  end
endmodule

// File: rtl/pmm_select.sv
module pmm_select
  import pmm_pkg::*;
(
  input  logic [EXT_W-1:0]  a_ext,
  input  logic [EXT_W-1:0]  b_ext,
  input  logic              a_sgn,
  input  logic              b_sgn,
  input  logic              want_max,
  input  logic              sat,
  input  logic              dst_sgn,
  output logic [WORD_W-1:0] value
);
  localparam logic [WORD_W-1:0] SIGNED_TOP = {1'b0, {(WORD_W-1){1'b1}}};

  logic              a_lt_b;
  logic              take_a;
  logic              res_sgn;
  logic [WORD_W-1:0] chosen;

  always_comb begin
    a_lt_b  = $signed(a_ext) < $signed(b_ext);
    take_a  = want_max ? !a_lt_b : a_lt_b;
    chosen  = take_a ? a_ext[WORD_W-1:0] : b_ext[WORD_W-1:0];
    res_sgn = (a_sgn == b_sgn) ? a_sgn : !want_max;

    value = chosen;
    if (sat) begin
      if (dst_sgn && !res_sgn && chosen[WORD_W-1]) begin
        value = SIGNED_TOP;
      end else if (!dst_sgn && res_sgn && chosen[WORD_W-1]) begin
        value = '0;
      end
    end
  end
endmodule

// File: rtl/pmm_post.sv
module pmm_post
  import pmm_pkg::*;
(
  input  logic [WORD_W-1:0] value,
  input  logic [WORD_W-1:0] src_c,
  input  post_op_e          post,
  input  logic              dst_sgn,
  output logic [WORD_W-1:0] out
);
  logic val_lt_c;

  always_comb begin
    val_lt_c = dst_sgn ? ($signed(value) < $signed(src_c)) : (value < src_c);
    case (post)
      POST_INS_HI16: out = {value[HALF_W-1:0], src_c[HALF_W-1:0]};
      POST_INS_LO16: out = {src_c[WORD_W-1:HALF_W], value[HALF_W-1:0]};
      POST_INS_B0:   out = {src_c[WORD_W-1:BYTE_W], value[BYTE_W-1:0]};
      POST_INS_B2:   out = {src_c[WORD_W-1:3*BYTE_W], value[BYTE_W-1:0], src_c[HALF_W-1:0]};
      POST_ADD:      out = value + src_c;
      POST_MIN:      out = val_lt_c ? value : src_c;
      POST_MAX:      out = val_lt_c ? src_c : value;
      default:       out = value;
    endcase
  end
endmodule

// File: rtl/packed_minmax_unit.sv
module packed_minmax_unit
  import pmm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [WORD_W-1:0]  src_a,
  input  logic [WORD_W-1:0]  src_b,
  input  logic [WORD_W-1:0]  src_c,
  output logic               out_valid,
  output logic [WORD_W-1:0]  result
);
  op_ctl_t           ctl;
  logic [EXT_W-1:0]  a_ext;
  logic [EXT_W-1:0]  b_reg_ext;
  logic [EXT_W-1:0]  b_ext;
  logic [WORD_W-1:0] picked;
  logic [WORD_W-1:0] post_out;

  logic              valid_d, valid_q;
  logic [WORD_W-1:0] result_d, result_q;

  pmm_decode u_decode (
    .instr (instr),
    .ctl   (ctl)
  );

  pmm_lane_extract u_ext_a (
    .raw (src_a),
    .ctl (ctl.a),
    .ext (a_ext)
  );

  pmm_lane_extract u_ext_b (
    .raw (src_b),
    .ctl (ctl.b),
    .ext (b_reg_ext)
  );

  assign b_ext = ctl.b_is_reg ? b_reg_ext
                              : {ctl.b.sgn & ctl.imm_ext[WORD_W-1], ctl.imm_ext};

  pmm_select u_select (
    .a_ext    (a_ext),
    .b_ext    (b_ext),
    .a_sgn    (ctl.a.sgn),
    .b_sgn    (ctl.b.sgn),
    .want_max (ctl.want_max),
    .sat      (ctl.sat),
    .dst_sgn  (ctl.dst_sgn),
    .value    (picked)
  );

  pmm_post u_post (
    .value   (picked),
    .src_c   (src_c),
    .post    (ctl.post),
    .dst_sgn (ctl.dst_sgn),
    .out     (post_out)
  );

  always_comb begin
    valid_d  = in_valid;
    result_d = in_valid ? post_out : result_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q  <= valid_d;
      result_q <= result_d;
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
endmodule

// File: rtl/pmm_checker.sv
module pmm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] instr,
  input logic [31:0] src_c,
  input logic        out_valid,
  input logic [31:0] result
);
  logic reset_seen;
  logic unused_chk_bits;

  assign unused_chk_bits = ^{instr[63:56], instr[47:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reset_seen <= 1'b1;
    else        reset_seen <= reset_seen;
  end

  always @(negedge clk) begin
    if (!rst_n && reset_seen === 1'b1) begin
      AST_RESET_CLEARS: assert (out_valid == 1'b0 && result == 32'd0); // R1
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R2

  AST_HI16_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[53:51] == 3'd0) |=> result[15:0] == $past(src_c[15:0])); // R10

  AST_B0_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[53:51] == 3'd2) |=> result[31:8] == $past(src_c[31:8])); // R10

  AST_SAT_SIGNED_DST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[55] && instr[54] && !instr[48] && !instr[49] && instr[53:51] == 3'd7)
      |=> !result[31]); // R8

  AST_SAT_UNSIGNED_DST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[55] && !instr[54] && instr[48] && instr[49] && instr[53:51] == 3'd7)
      |=> !result[31]); // R9
endmodule

bind packed_minmax_unit pmm_checker u_pmm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .instr     (instr),
  .src_c     (src_c),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/packed_minmax_unit_bench.sv
module packed_minmax_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 1500;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] instr;
  logic [31:0] src_a, src_b, src_c;
  logic        out_valid;
  logic [31:0] result;

  int checks;
  int errors;
  bit done;

  packed_minmax_unit u_packed_minmax_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .src_a     (src_a),
    .src_b     (src_b),
    .src_c     (src_c),
    .out_valid (out_valid),
    .result    (result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [2:0] af, input logic a_s, input logic breg,
                                     input logic [2:0] bf, input logic b_s, input logic [19:0] imm,
                                     input logic mx, input logic sat, input logic ds,
                                     input logic [2:0] post);
    logic [63:0] w;
    w = '0;
    w[38:36] = af;
    w[48]    = a_s;
    w[50]    = breg;
    if (breg) w[30:28] = bf;
    else      w[35:16] = imm;
    w[49]    = b_s;
    w[56]    = mx;
    w[55]    = sat;
    w[54]    = ds;
    w[53:51] = post;
    return w;
  endfunction

  function automatic longint ext_op(input logic [31:0] v, input logic [2:0] f, input logic s);
    longint r;
    logic [15:0] h;
    logic [7:0]  b8;
    if (f[2:1] == 2'd3) begin
      r = s ? longint'($signed(v)) : longint'(v);
    end else if (f[2:1] == 2'd2) begin
      h = f[0] ? v[31:16] : v[15:0];
      r = s ? longint'($signed(h)) : longint'(h);
    end else begin
      b8 = v[f[1:0]*8 +: 8];
      r = s ? longint'($signed(b8)) : longint'(b8);
    end
    return r;
  endfunction

  function automatic logic [31:0] model(input logic [63:0] w, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] c);
    longint av, bv, r;
    logic rs, mx, ds;
    logic [31:0] v;
    logic lt;
    mx = w[56];
    ds = w[54];
    av = ext_op(a, w[38:36], w[48]);
    if (w[50]) bv = ext_op(b, w[30:28], w[49]);
    else       bv = w[49] ? longint'($signed(w[35:16])) : longint'(w[35:16]);
    r  = mx ? ((av > bv) ? av : bv) : ((av < bv) ? av : bv);
    rs = (w[48] == w[49]) ? w[48] : !mx;
    if (w[55]) begin
      if (ds && !rs && r > 64'sh7FFFFFFF) r = 64'sh7FFFFFFF;
      else if (!ds && rs && r < 0)        r = 0;
    end
    v  = r[31:0];
    lt = ds ? ($signed(v) < $signed(c)) : (v < c);
    case (w[53:51])
      3'd0:    return {v[15:0], c[15:0]};
      3'd1:    return {c[31:16], v[15:0]};
      3'd2:    return {c[31:8], v[7:0]};
      3'd3:    return {c[31:24], v[7:0], c[15:0]};
      3'd4:    return v + c;
      3'd5:    return lt ? v : c;
      3'd6:    return lt ? c : v;
      default: return v;
    endcase
  endfunction

  task automatic run(input string tag, input logic [63:0] w, input logic [31:0] a,
                     input logic [31:0] b, input logic [31:0] c, input logic [31:0] exp);
    @(negedge clk);
    instr = w; src_a = a; src_b = b; src_c = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 out_valid after strobe", {31'd0, out_valid}, 32'd1);
    check(tag, result, exp);
    instr = {$urandom, $urandom}; src_a = $urandom; src_b = $urandom; src_c = $urandom;
    @(negedge clk);
    check("R2 out_valid idle", {31'd0, out_valid}, 32'd0);
    check("R2 result held while idle", result, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog expired: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    void'($urandom(32'd20250601));
    rst_n = 1'b0; in_valid = 1'b0; instr = '0;
    src_a = '0; src_b = '0; src_c = '0;
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset result", result, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // operand A lanes and sizes
    run("R3 byte lane 2 signed min", mk(3'b010,1,1,3'b110,0,0,0,0,0,3'd7), 32'h0080_0000, 32'd5, 0, 32'hFFFF_FF80);
    run("R3 upper half signed min", mk(3'b101,1,1,3'b110,1,0,0,0,0,3'd7), 32'h8001_1234, 32'hFFFF_FFFF, 0, 32'hFFFF_8001);
    // operand B register lanes
    run("R4 B byte lane 3 signed", mk(3'b110,0,1,3'b011,1,0,1,0,0,3'd7), 32'h10, 32'h7F00_0000, 0, 32'h7F);
    run("R4 B lower half unsigned", mk(3'b110,0,1,3'b100,0,0,1,0,0,3'd7), 32'h0, 32'h1234_ABCD, 0, 32'hABCD);
    // immediate
    run("R5 signed immediate", mk(3'b110,1,0,0,1,20'hFFFFE,0,0,0,3'd7), 32'd5, 32'hDEAD_BEEF, 0, 32'hFFFF_FFFE);
    run("R5 unsigned immediate", mk(3'b110,0,0,0,0,20'hFFFFE,1,0,0,3'd7), 32'h10, 32'hDEAD_BEEF, 0, 32'h000F_FFFE);
    // same signedness
    run("R6 unsigned min", mk(3'b110,0,1,3'b110,0,0,0,0,0,3'd7), 32'hFFFF_FFFF, 32'd1, 0, 32'd1);
    run("R6 signed max", mk(3'b110,1,1,3'b110,1,0,1,0,0,3'd7), 32'hFFFF_FFFF, 32'd1, 0, 32'd1);
    run("R6 signed min", mk(3'b110,1,1,3'b110,1,0,0,0,0,3'd7), 32'hFFFF_FFFF, 32'd1, 0, 32'hFFFF_FFFF);
    // mixed signedness
    run("R7 mixed max", mk(3'b110,1,1,3'b110,0,0,1,0,0,3'd7), 32'hFFFF_FFFF, 32'h8000_0000, 0, 32'h8000_0000);
    run("R7 mixed min", mk(3'b110,1,1,3'b110,0,0,0,0,0,3'd7), 32'hFFFF_FFFF, 32'h8000_0000, 0, 32'hFFFF_FFFF);
    // saturation
    run("R8 clamp to signed top", mk(3'b110,0,1,3'b110,0,0,1,1,1,3'd7), 32'h9000_0000, 32'd1, 0, 32'h7FFF_FFFF);
    run("R8 no clamp without sat", mk(3'b110,0,1,3'b110,0,0,1,0,1,3'd7), 32'h9000_0000, 32'd1, 0, 32'h9000_0000);
    run("R9 signed negative to zero", mk(3'b110,1,1,3'b110,1,0,0,1,0,3'd7), 32'hFFFF_FFF0, 32'd3, 0, 32'd0);
    run("R9 mixed min to zero", mk(3'b110,1,1,3'b110,0,0,0,1,0,3'd7), 32'hFFFF_FFFB, 32'd7, 0, 32'd0);
    // post operations
    run("R10 insert high half", mk(3'b110,0,1,3'b110,0,0,1,0,0,3'd0), 32'h1234, 0, 32'hAAAA_BBBB, 32'h1234_BBBB);
    run("R10 insert low half", mk(3'b110,0,1,3'b110,0,0,1,0,0,3'd1), 32'h1234, 0, 32'hAAAA_BBBB, 32'hAAAA_1234);
    run("R10 insert byte 0", mk(3'b110,0,1,3'b110,0,0,1,0,0,3'd2), 32'h56, 0, 32'hAAAA_BBBB, 32'hAAAA_BB56);
    run("R10 insert byte 2", mk(3'b110,0,1,3'b110,0,0,1,0,0,3'd3), 32'h56, 0, 32'hAAAA_BBBB, 32'hAA56_BBBB);
    run("R11 accumulate wraps", mk(3'b110,0,1,3'b110,0,0,1,0,0,3'd4), 32'hFFFF_FFF0, 0, 32'h20, 32'h10);
    run("R11 pass through", mk(3'b110,0,1,3'b110,0,0,1,0,0,3'd7), 32'hCAFE_0001, 0, 32'h20, 32'hCAFE_0001);
    run("R12 min with C signed", mk(3'b110,0,1,3'b110,0,0,1,0,1,3'd5), 32'd5, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run("R12 min with C unsigned", mk(3'b110,0,1,3'b110,0,0,1,0,0,3'd5), 32'd5, 0, 32'hFFFF_FFFF, 32'd5);
    run("R12 max with C signed", mk(3'b110,0,1,3'b110,0,0,1,0,1,3'd6), 32'd5, 0, 32'hFFFF_FFFF, 32'd5);
    run("R12 max with C unsigned", mk(3'b110,0,1,3'b110,0,0,1,0,0,3'd6), 32'd5, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

    // random instruction words against the model (R3..R12)
    for (int i = 0; i < N_RANDOM; i++) begin
      logic [63:0] w;
      logic [31:0] a, b, c;
      w = {$urandom, $urandom};
      a = $urandom; b = $urandom; c = $urandom;
      if (i % 4 == 0) a = {a[31], 31'h0};
      if (i % 5 == 0) b = {1'b1, b[30:0]};
      run("R7 random vector vs model", w, a, b, c, model(w, a, b, c));
    end

    // asynchronous reset mid-run
    run("R6 before reset", mk(3'b110,0,1,3'b110,0,0,1,0,0,3'd7), 32'h55, 32'h11, 0, 32'h55);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R1 async clear result", result, 32'd0);
    check("R1 async clear out_valid", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    run("R2 operation after reset", mk(3'b110,0,1,3'b110,0,0,0,0,0,3'd7), 32'h55, 32'h11, 0, 32'h11);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule